// File: doc/BRIEF.md
# UART Interrupt Status Combiner

This block gathers the interrupt causes of a UART into one raw status vector. A mask register selects which causes may reach the interrupt controller. The block shows the raw status, the mask and the masked status as outputs, and it drives one interrupt request line, which is the OR of all masked bits. A service routine reads the masked status to find every pending cause in one pass, and it acknowledges the error and timeout causes by writing ones to a clear strobe.

Five causes are errors or timeouts: overrun, break, parity, framing and receive timeout. Each one arrives as a single-cycle pulse and is held in the status until software clears it. The receive cause and the transmit cause are level conditions. Their status bits track the condition with a one-cycle register delay and cannot be cleared.

The transmit cause has two sources, picked by a mode input. In the default mode it is the transmit FIFO threshold condition. In end-of-transmission mode it is the condition that the last bit of all queued data has left the serializer.

Top module: `uart_irq_combiner`

## Requirements
- R1: Status bit positions are fixed: bit 0 overrun, bit 1 break, bit 2 parity, bit 3 framing, bit 4 receive timeout, bit 5 transmit, bit 6 receive. After reset, `raw_stat`, `mask_q`, `masked_stat` and `irq` are all zero.
- R2: When `err_evt[i]` (i = 0..4, in the bit order of R1) is high at a clock edge, `raw_stat[i]` reads 1 from the next cycle on. It stays 1 until it is cleared as described in R3.
- R3: When `clr_we` is high at an edge and `clr_wdata[i]` is 1, sticky bit i (i = 0..4) reads 0 from the next cycle on. If a pulse on `err_evt[i]` arrives at the same edge, the bit stays 1. Zero bits in `clr_wdata` leave their status bits unchanged.
- R4: `raw_stat[6]` equals the value `rx_lvl` had one cycle earlier. A clear write does not affect bits 5 and 6.
- R5: `raw_stat[5]` equals the value one cycle earlier of `tx_lvl` when `eot_mode` was 0, or of `tx_idle` when `eot_mode` was 1.
- R6: When `mask_we` is high at an edge, `mask_q` takes the value of `mask_wdata` from the next cycle on. Otherwise `mask_q` holds its value.
- R7: `masked_stat` equals `raw_stat & mask_q`. The mask never changes `raw_stat`.
- R8: `irq` is 1 exactly when some bit of `masked_stat` is 1. It therefore stays low after reset until software sets mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | 5 | Error/timeout event pulses (R1 order, bits 0..4) |
| rx_lvl | input | 1 | Receive FIFO threshold condition |
| tx_lvl | input | 1 | Transmit FIFO threshold condition |
| tx_idle | input | 1 | Last bit of all queued data has left the serializer |
| eot_mode | input | 1 | 1 selects end-of-transmission as the transmit cause |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 7 | Mask write data |
| clr_we | input | 1 | Clear register write strobe |
| clr_wdata | input | 7 | Write-one-to-clear data |
| raw_stat | output | 7 | Raw interrupt status |
| mask_q | output | 7 | Current mask |
| masked_stat | output | 7 | Raw status ANDed with mask |
| irq | output | 1 | Single interrupt request |

## Verification
The bench first pulses each error cause on its own while the mask is zero. This separates raw visibility from request generation and shows that each bit sits at the right position. It then runs clear writes that cover a partial set of bits, that arrive on the same edge as a new event, and that target the level bits. These tell sticky behaviour apart from level tracking and confirm that set wins over clear. It also toggles `eot_mode` while `tx_lvl` and `tx_idle` disagree, which shows which source drives the transmit bit. A long pseudo-random phase then mixes all inputs, and a behavioural model is compared with the outputs on every cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int unsigned NUM_SRC   = 7;
  localparam int unsigned NUM_STICK = 5;
  localparam int unsigned TX_BIT    = 5;
  localparam int unsigned RX_BIT    = 6;

  // Next value of a sticky bit group: a set pulse outranks a clear.
  function automatic logic [NUM_STICK-1:0] sticky_next(
    input logic [NUM_STICK-1:0] cur,
    input logic [NUM_STICK-1:0] set_v,
    input logic [NUM_STICK-1:0] clr_v
  );
    return (cur & ~clr_v) | set_v;
  endfunction

  // Transmit cause selection.
  function automatic logic tx_cause(input logic eot, input logic lvl, input logic idle);
    return eot ? idle : lvl;
  endfunction
endpackage

// File: rtl/uirq_sticky_bank.sv
module uirq_sticky_bank
  import uirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_STICK-1:0] set_v,
  input  logic [NUM_STICK-1:0] clr_v,
  output logic [NUM_STICK-1:0] q
);
  logic [NUM_STICK-1:0] nxt;
  assign nxt = sticky_next(q, set_v, clr_v);

  for (genvar i = 0; i < NUM_STICK; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/uirq_level_stage.sv
module uirq_level_stage
  import uirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_lvl,
  input  logic tx_lvl,
  input  logic tx_idle,
  input  logic eot_mode,
  output logic tx_q,
  output logic rx_q
);
  logic tx_sel;
  assign tx_sel = tx_cause(eot_mode, tx_lvl, tx_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_sel;
      rx_q <= rx_lvl;
    end
  end
endmodule

// File: rtl/uirq_mask_reg.sv
module uirq_mask_reg
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
  import uirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_STICK-1:0] err_evt,
  input  logic                 rx_lvl,
  input  logic                 tx_lvl,
  input  logic                 tx_idle,
  input  logic                 eot_mode,
  input  logic                 mask_we,
  input  logic [NUM_SRC-1:0]   mask_wdata,
  input  logic                 clr_we,
  input  logic [NUM_SRC-1:0]   clr_wdata,
  output logic [NUM_SRC-1:0]   raw_stat,
  output logic [NUM_SRC-1:0]   mask_q,
  output logic [NUM_SRC-1:0]   masked_stat,
  output logic                 irq
);
  // Named internal events, visible to the checker.
  logic [NUM_STICK-1:0] clr_hit;
  logic [NUM_STICK-1:0] sticky_q;
  logic                 tx_q;
  logic                 rx_q;

  assign clr_hit = clr_we ? clr_wdata[NUM_STICK-1:0] : '0;

  uirq_sticky_bank u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_v (err_evt),
    .clr_v (clr_hit),
    .q     (sticky_q)
  );

  uirq_level_stage u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_lvl   (rx_lvl),
    .tx_lvl   (tx_lvl),
    .tx_idle  (tx_idle),
    .eot_mode (eot_mode),
    .tx_q     (tx_q),
    .rx_q     (rx_q)
  );

  uirq_mask_reg u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mask_we),
    .wdata (mask_wdata),
    .q     (mask_q)
  );

  assign raw_stat    = {rx_q, tx_q, sticky_q};
  assign masked_stat = raw_stat & mask_q;
  assign irq         = |masked_stat;
endmodule

// File: rtl/uart_irq_combiner_chk.sv
module uart_irq_combiner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] err_evt,
  input logic       rx_lvl,
  input logic       tx_lvl,
  input logic       tx_idle,
  input logic       eot_mode,
  input logic       mask_we,
  input logic       clr_we,
  input logic [6:0] clr_wdata,
  input logic [6:0] raw_stat,
  input logic [6:0] mask_q,
  input logic       irq
);
  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_evt) |=> ((raw_stat[4:0] & $past(err_evt)) == $past(err_evt)));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_we) |=> ((($past(raw_stat[4:0])) & ~raw_stat[4:0]) == 5'd0));

  // R4
  rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_stat[6] == $past(rx_lvl)));

  // R5
  tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_stat[5] == ($past(eot_mode) ? $past(tx_idle) : $past(tx_lvl))));

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_we) |=> $stable(mask_q));

  // R8
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw_stat & mask_q)));
endmodule

bind uart_irq_combiner uart_irq_combiner_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_evt   (err_evt),
  .rx_lvl    (rx_lvl),
  .tx_lvl    (tx_lvl),
  .tx_idle   (tx_idle),
  .eot_mode  (eot_mode),
  .mask_we   (mask_we),
  .clr_we    (clr_we),
  .clr_wdata (clr_wdata),
  .raw_stat  (raw_stat),
  .mask_q    (mask_q),
  .irq       (irq)
);

// File: tb/uart_irq_combiner_test.sv
module uart_irq_combiner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] err_evt = '0;
  logic       rx_lvl = 1'b0, tx_lvl = 1'b0, tx_idle = 1'b0, eot_mode = 1'b0;
  logic       mask_we = 1'b0, clr_we = 1'b0;
  logic [6:0] mask_wdata = '0, clr_wdata = '0;
  logic [6:0] raw_stat, mask_q, masked_stat;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_irq_combiner uut (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .rx_lvl(rx_lvl),
    .tx_lvl(tx_lvl), .tx_idle(tx_idle), .eot_mode(eot_mode),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .clr_we(clr_we),
    .clr_wdata(clr_wdata), .raw_stat(raw_stat), .mask_q(mask_q),
    .masked_stat(masked_stat), .irq(irq)
  );

  // Behavioural reference: one flag per cause, one per mask bit.
  bit ref_flag [7];
  bit ref_mask [7];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 7; k++) begin ref_flag[k] <= 0; ref_mask[k] <= 0; end
    end else begin
      for (int k = 0; k < 5; k++) begin
        if (err_evt[k])                    ref_flag[k] <= 1;
        else if (clr_we && clr_wdata[k])   ref_flag[k] <= 0;
      end
      if (eot_mode) ref_flag[5] <= tx_idle; else ref_flag[5] <= tx_lvl;
      ref_flag[6] <= rx_lvl;
      if (mask_we) for (int k = 0; k < 7; k++) ref_mask[k] <= mask_wdata[k];
    end
  end

  function automatic logic [6:0] ref_raw();
    logic [6:0] v;
    for (int k = 0; k < 7; k++) v[k] = ref_flag[k];
    return v;
  endfunction

  function automatic logic [6:0] ref_msk();
    logic [6:0] v;
    for (int k = 0; k < 7; k++) v[k] = ref_mask[k];
    return v;
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output against the reference, at the falling edge.
  task automatic compare_all();
    logic [6:0] r, m, e;
    int pend;
    r = ref_raw();
    m = ref_msk();
    e = 7'd0;
    pend = 0;
    for (int k = 0; k < 7; k++) begin
      e[k] = r[k] && m[k];
      if (r[k] && m[k]) pend++;
    end
    check("R2/R3 sticky bits", {2'b00, raw_stat[4:0]}, {2'b00, r[4:0]});
    check("R5 tx bit", {6'd0, raw_stat[5]}, {6'd0, r[5]});
    check("R4 rx bit", {6'd0, raw_stat[6]}, {6'd0, r[6]});
    check("R6 mask", mask_q, m);
    check("R7 masked status", masked_stat, e);
    check("R8 irq", {6'd0, irq}, {6'd0, pend > 0});
  endtask

  // Advance one cycle: compare, then drive the next inputs.
  task automatic cyc(input logic [4:0] ev, input logic cw, input logic [6:0] cd,
                     input logic mw, input logic [6:0] md);
    @(negedge clk);
    compare_all();
    err_evt = ev; clr_we = cw; clr_wdata = cd; mask_we = mw; mask_wdata = md;
  endtask

  task automatic idle_cyc(); cyc(5'd0, 1'b0, 7'd0, 1'b0, 7'd0); endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset raw", raw_stat, 7'd0);
    check("R1 reset mask", mask_q, 7'd0);
    check("R1 reset irq", {6'd0, irq}, 7'd0);
    rst_n = 1'b1;
    idle_cyc();

    // R2/R7/R8: each error alone, mask zero, raw visible, irq low
    for (int k = 0; k < 5; k++) begin
      cyc(5'd1 << k, 1'b0, 7'd0, 1'b0, 7'd0);
      idle_cyc();
      @(negedge clk);
      check("R1 bit position", raw_stat, ref_raw());
      check("R8 irq low with zero mask", {6'd0, irq}, 7'd0);
    end

    // R6: enable everything
    cyc(5'd0, 1'b0, 7'd0, 1'b1, 7'h7F);
    idle_cyc();
    // R3: partial clear of bits 0 and 2
    cyc(5'd0, 1'b1, 7'b0000101, 1'b0, 7'd0);
    idle_cyc();
    // R3: set and clear on bit 1 at the same edge: set wins
    cyc(5'b00010, 1'b1, 7'b0000010, 1'b0, 7'd0);
    idle_cyc();
    @(negedge clk);
    check("R3 set outranks clear", {6'd0, raw_stat[1]}, 7'd1);

    // R4: level bits ignore clear
    rx_lvl = 1'b1; tx_lvl = 1'b1;
    idle_cyc();
    cyc(5'd0, 1'b1, 7'b1100000, 1'b0, 7'd0);
    idle_cyc();
    @(negedge clk);
    check("R4 clear ignored on level bits", raw_stat[6:5], 2'b11);

    // R5: sources disagree, flip the mode
    tx_lvl = 1'b0; tx_idle = 1'b1;
    idle_cyc();
    eot_mode = 1'b1;
    idle_cyc(); idle_cyc();
    tx_idle = 1'b0; tx_lvl = 1'b1;
    idle_cyc(); idle_cyc();
    eot_mode = 1'b0;
    idle_cyc(); idle_cyc();
    rx_lvl = 1'b0;

    // Clear all, mask only rx: irq follows rx alone
    cyc(5'd0, 1'b1, 7'h7F, 1'b1, 7'b1000000);
    tx_lvl = 1'b0;
    idle_cyc(); idle_cyc();
    rx_lvl = 1'b1;
    idle_cyc(); idle_cyc();
    rx_lvl = 1'b0;
    idle_cyc(); idle_cyc();

    // Mixed pseudo-random phase
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rx_lvl = lfsr[0]; tx_lvl = lfsr[3]; tx_idle = lfsr[7]; eot_mode = lfsr[11];
      cyc((lfsr[4:2] == 3'd0) ? lfsr[9:5] : 5'd0,
          lfsr[12] & lfsr[1], lfsr[15:9],
          lfsr[14] & lfsr[13] & lfsr[8], lfsr[6:0]);
    end
    idle_cyc(); idle_cyc();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule